// File: doc/BRIEF.md
# DDR Command Bus Protocol Monitor

This block is a passive observer for a DDR SDRAM control and address bus. It samples the clock enable, chip select, row and column strobes, write enable, bank address and address lines on every rising clock edge and decodes the command that was presented. For each of the four banks it tracks two things: whether the bank is idle or holds an open row, and which row that is. It judges every command against that state.

Legal column accesses come out as one-cycle read or write strobes carrying the bank, the open row, the column and the auto-precharge request. Auto-precharge closes a bank only once its burst has ended. The burst length is taken from legal mode-register writes. Write data masks are counted over each write burst. Protocol violations set sticky flags and a last-error code. The monitor never drives the bus; it is meant to sit beside a controller in simulation or silicon debug logic.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: The command sampled at a rising edge appears on `cmdCode` after that edge. The codes are 0 deselect (chip select high, any other pins), 1 NOP, 2 activate, 3 read, 4 write, 5 precharge one bank, 6 precharge all, 7 auto refresh, 8 self-refresh entry, 9 mode-register write and 10 burst stop. A deselect changes no bank state.
- R2: An activate opens the row on `addr` in the bank on `ba`. A legal read or write raises `rdStrobe` or `wrStrobe` for one cycle. That cycle carries `burstBank`, the bank's open row on `burstRow`, and on `burstCol` the address with bit 10 removed (`{addr[13:11], addr[9:0]}`). The burst fields hold between strobes.
- R3: A read or write to an idle bank raises no strobe and records error code 1.
- R4: A read or write with `addr[10]` high reports `autoPre`. The bank stays open for commands sampled during the next BL/2 clocks and is idle for a command sampled BL/2+1 clocks after the access.
- R5: A read or write with `addr[10]` low leaves the row open indefinitely.
- R6: Precharge with `addr[10]` low closes only the bank on `ba`. With `addr[10]` high it closes every bank and `ba` is ignored.
- R7: A mode-register write while any bank is open records error code 2 and is discarded. A legal one with `ba`=0 sets the burst length from `addr[2:0]`: 1 gives 2, 2 gives 4, 3 gives 8, and any other value keeps the current length. The length after reset is 4.
- R8: A refresh command sampled with `cke` high is auto refresh. With `cke` low it is self-refresh entry.
- R9: After self-refresh entry, or after a NOP or deselect sampled with `cke` low (power-down), the monitor is in low power. Any command other than NOP or deselect then records error code 3 and has no effect. A NOP or deselect with `cke` high leaves low power. Open rows survive power-down.
- R10: Activating a bank that already has an open row records error code 4 and keeps the old row.
- R11: `dm[1:0]` gives the mask of the two data beats of a clock. It is counted over the BL/2 clocks that follow a legal write. On the last of those clocks, `maskValid` pulses and `maskCount` shows the number of masked beats. A new write restarts the count.
- R12: `errFlags` bit k-1 is set for error code k and never clears until reset. `errCode` holds the most recent error code.
- R13: Under reset all outputs are zero, all banks are idle and the monitor is not in low power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge sampled |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Address lines |
| dm | input | 2 | Data mask of the two beats in a clock |
| cmdCode | output | 4 | Decoded command code |
| rdStrobe | output | 1 | Legal read burst start |
| wrStrobe | output | 1 | Legal write burst start |
| burstBank | output | 2 | Bank of the last legal access |
| burstRow | output | 14 | Open row of that bank |
| burstCol | output | 13 | Column of the last legal access |
| autoPre | output | 1 | Auto-precharge requested with the strobe |
| maskValid | output | 1 | Masked-beat count valid |
| maskCount | output | 4 | Masked beats in the finished write burst |
| errFlags | output | 4 | Sticky violation flags |
| errCode | output | 3 | Most recent violation code |

## Verification
The bench targets the auto-precharge window. It accesses the bank on the last clock before the close and again on the first clock after it. A design that is off by one there either rejects a legal access or admits one to a closed bank. It checks that an illegal mode-register write leaves the burst length alone, which shows up as the write-mask report arriving after the old number of clocks. Low-power entry from both self refresh and power-down is followed by a blocked activate and a later access; a monitor that let the blocked command through would report a strobe instead of an idle-bank error. Precharge-all is given a nonzero bank field, and an activate is presented with chip select high, so that a design decoding those pins wrongly would close too little or open a row.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  localparam int ERR_KINDS = 4;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_RD     = 4'd3,
    CMD_WR     = 4'd4,
    CMD_PRE    = 4'd5,
    CMD_PREALL = 4'd6,
    CMD_AREF   = 4'd7,
    CMD_SREF   = 4'd8,
    CMD_MRS    = 4'd9,
    CMD_BST    = 4'd10
  } cmdE;

  typedef enum logic [2:0] {
    ERR_NONE        = 3'd0,
    ERR_IDLE_ACCESS = 3'd1,
    ERR_MRS_ACTIVE  = 3'd2,
    ERR_LOWPWR_CMD  = 3'd3,
    ERR_ACT_OPEN    = 3'd4
  } errE;

  // Strobes from the control to the bank datapath, already qualified as legal.
  typedef struct packed {
    logic openRow;
    logic access;
    logic isWrite;
    logic closeOne;
    logic closeAll;
    logic loadMode;
  } bankCtrlT;

endpackage

// File: rtl/ddrmon_ctrl.sv
module ddrmon_ctrl
  import ddrmon_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cke,
  input  logic                      csN,
  input  logic                      rasN,
  input  logic                      casN,
  input  logic                      weN,
  input  logic [BANK_W-1:0]         ba,
  input  logic                      apBit,
  input  logic [(1<<BANK_W)-1:0]    bankActive,
  output bankCtrlT                  ctrl,
  output logic [3:0]                cmdCode,
  output logic [ERR_KINDS-1:0]      errFlags,
  output logic [2:0]                errCode
);

  cmdE  cmd;
  errE  errNow;
  logic lowPower;
  logic idleCmd, blocked, legal;
  logic [ERR_KINDS-1:0] errHot;

  always_comb begin
    cmd = CMD_BST;
    if (csN) begin
      cmd = CMD_DESEL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = apBit ? CMD_PREALL : CMD_PRE;
        3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_BST;
      endcase
    end
  end

  assign idleCmd = (cmd == CMD_DESEL) || (cmd == CMD_NOP);
  assign blocked = lowPower && !idleCmd;

  always_comb begin
    errNow = ERR_NONE;
    if (blocked)
      errNow = ERR_LOWPWR_CMD;
    else if ((cmd == CMD_RD || cmd == CMD_WR) && !bankActive[ba])
      errNow = ERR_IDLE_ACCESS;
    else if (cmd == CMD_MRS && (|bankActive))
      errNow = ERR_MRS_ACTIVE;
    else if (cmd == CMD_ACT && bankActive[ba])
      errNow = ERR_ACT_OPEN;
  end

  assign legal = !blocked && (errNow == ERR_NONE);

  always_comb begin
    ctrl.openRow  = legal && (cmd == CMD_ACT);
    ctrl.access   = legal && (cmd == CMD_RD || cmd == CMD_WR);
    ctrl.isWrite  = (cmd == CMD_WR);
    ctrl.closeOne = legal && (cmd == CMD_PRE);
    ctrl.closeAll = legal && (cmd == CMD_PREALL);
    ctrl.loadMode = legal && (cmd == CMD_MRS);
  end

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_errHot
    assign errHot[k] = (errNow == errE'(k + 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowPower <= 1'b0;
      cmdCode  <= '0;
      errFlags <= '0;
      errCode  <= '0;
    end else begin
      cmdCode  <= cmd;
      errFlags <= errFlags | errHot;
      if (errNow != ERR_NONE) errCode <= errNow;
      if (!blocked) begin
        if (!lowPower && (cmd == CMD_SREF || (idleCmd && !cke)))
          lowPower <= 1'b1;
        else if (lowPower && idleCmd && cke)
          lowPower <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddrmon_dp.sv
module ddrmon_dp
  import ddrmon_pkg::*;
#(
  parameter int BANK_W          = 2,
  parameter int ADDR_W          = 14,
  parameter int RESET_BURST_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankCtrlT                  ctrl,
  input  logic [BANK_W-1:0]         ba,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                dm,
  output logic [(1<<BANK_W)-1:0]    bankActive,
  output logic                      rdStrobe,
  output logic                      wrStrobe,
  output logic [BANK_W-1:0]         burstBank,
  output logic [ADDR_W-1:0]         burstRow,
  output logic [ADDR_W-2:0]         burstCol,
  output logic                      autoPre,
  output logic                      maskValid,
  output logic [3:0]                maskCount
);

  localparam int NB       = 1 << BANK_W;
  localparam int ROW_W    = ADDR_W;
  localparam int COL_W    = ADDR_W - 1;
  localparam int AP_BIT   = 10;
  localparam int CNT_W    = 3;
  localparam int MASK_W   = 4;
  localparam int DEF_HALF = RESET_BURST_LEN / 2;

  logic [CNT_W-1:0]    blHalf;
  logic [NB*ROW_W-1:0] rowFlat;
  logic [ROW_W-1:0]    rowSel;
  logic [COL_W-1:0]    colNow;
  logic [CNT_W-1:0]    wrRemain;
  logic [MASK_W-1:0]   maskAcc, dmOnes;

  assign rowSel = rowFlat[ba*ROW_W +: ROW_W];
  assign colNow = {addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};
  assign dmOnes = MASK_W'(dm[0]) + MASK_W'(dm[1]);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic             actQ;
    logic [ROW_W-1:0] rowQ;
    logic [CNT_W-1:0] apCnt;
    logic             isSel;
    assign isSel = (ba == BANK_W'(i));
    assign bankActive[i] = actQ;
    assign rowFlat[i*ROW_W +: ROW_W] = rowQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ  <= 1'b0;
        rowQ  <= '0;
        apCnt <= '0;
      end else if (ctrl.closeAll || (ctrl.closeOne && isSel)) begin
        actQ  <= 1'b0;
        apCnt <= '0;
      end else if (ctrl.openRow && isSel) begin
        actQ <= 1'b1;
        rowQ <= addr;
      end else if (ctrl.access && isSel && addr[AP_BIT]) begin
        apCnt <= blHalf;
      end else if (apCnt == CNT_W'(1)) begin
        actQ  <= 1'b0;
        apCnt <= '0;
      end else if (apCnt != '0) begin
        apCnt <= apCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blHalf <= CNT_W'(DEF_HALF);
    end else if (ctrl.loadMode && ba == '0) begin
      case (addr[2:0])
        3'd1:    blHalf <= CNT_W'(1);
        3'd2:    blHalf <= CNT_W'(2);
        3'd3:    blHalf <= CNT_W'(4);
        default: blHalf <= blHalf;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStrobe  <= 1'b0;
      wrStrobe  <= 1'b0;
      autoPre   <= 1'b0;
      burstBank <= '0;
      burstRow  <= '0;
      burstCol  <= '0;
    end else begin
      rdStrobe <= ctrl.access && !ctrl.isWrite;
      wrStrobe <= ctrl.access && ctrl.isWrite;
      autoPre  <= ctrl.access && addr[AP_BIT];
      if (ctrl.access) begin
        burstBank <= ba;
        burstRow  <= rowSel;
        burstCol  <= colNow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrRemain  <= '0;
      maskAcc   <= '0;
      maskValid <= 1'b0;
      maskCount <= '0;
    end else begin
      maskValid <= (wrRemain == CNT_W'(1));
      if (wrRemain == CNT_W'(1)) maskCount <= maskAcc + dmOnes;
      if (ctrl.access && ctrl.isWrite) begin
        wrRemain <= blHalf;
        maskAcc  <= '0;
      end else if (wrRemain != '0) begin
        wrRemain <= wrRemain - CNT_W'(1);
        maskAcc  <= maskAcc + dmOnes;
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BANK_W          = 2,
  parameter int ADDR_W          = 14,
  parameter int RESET_BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cke,
  input  logic                  csN,
  input  logic                  rasN,
  input  logic                  casN,
  input  logic                  weN,
  input  logic [BANK_W-1:0]     ba,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            dm,
  output logic [3:0]            cmdCode,
  output logic                  rdStrobe,
  output logic                  wrStrobe,
  output logic [BANK_W-1:0]     burstBank,
  output logic [ADDR_W-1:0]     burstRow,
  output logic [ADDR_W-2:0]     burstCol,
  output logic                  autoPre,
  output logic                  maskValid,
  output logic [3:0]            maskCount,
  output logic [ERR_KINDS-1:0]  errFlags,
  output logic [2:0]            errCode
);

  localparam int NB = 1 << BANK_W;

  bankCtrlT        ctrl;
  logic [NB-1:0]   bankActive;

  ddrmon_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .apBit(addr[10]), .bankActive(bankActive),
    .ctrl(ctrl), .cmdCode(cmdCode), .errFlags(errFlags), .errCode(errCode)
  );

  ddrmon_dp #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .RESET_BURST_LEN(RESET_BURST_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .ba(ba), .addr(addr), .dm(dm),
    .bankActive(bankActive), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .burstBank(burstBank), .burstRow(burstRow), .burstCol(burstCol),
    .autoPre(autoPre), .maskValid(maskValid), .maskCount(maskCount)
  );

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [3:0] cmdCode,
  input logic       rdStrobe,
  input logic       wrStrobe,
  input logic       autoPre,
  input logic       maskValid,
  input logic [3:0] maskCount,
  input logic [3:0] errFlags,
  input logic [2:0] errCode
);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  p_rd_strobe_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> cmdCode == 4'd3);

  p_wr_strobe_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> cmdCode == 4'd4);

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (cmdCode == 4'd0 && !rdStrobe && !wrStrobe));

  p_autopre_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (rdStrobe || wrStrobe));

  p_mask_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    maskValid |-> maskCount <= 4'd8);

  p_sticky_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags != 4'd0) |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  p_code_flag_agree_r12: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 3'd0) == (errFlags != 4'd0));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .cmdCode(cmdCode), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .autoPre(autoPre), .maskValid(maskValid),
  .maskCount(maskCount), .errFlags(errFlags), .errCode(errCode)
);

// File: tb/test_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module test_ddr_cmd_monitor;

  localparam int DESEL = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 5,
                 PREALL = 6, REF = 7, MRS = 9, BST = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [13:0] addr = '0;
  logic [1:0]  dm = '0;
  logic [3:0]  cmdCode, maskCount, errFlags;
  logic        rdStrobe, wrStrobe, autoPre, maskValid;
  logic [1:0]  burstBank;
  logic [13:0] burstRow;
  logic [12:0] burstCol;
  logic [2:0]  errCode;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ddr_cmd_monitor i_ddr_cmd_monitor (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .dm(dm), .cmdCode(cmdCode),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .burstBank(burstBank),
    .burstRow(burstRow), .burstCol(burstCol), .autoPre(autoPre),
    .maskValid(maskValid), .maskCount(maskCount), .errFlags(errFlags),
    .errCode(errCode)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mActive[4], mRow[4], mAp[4];
  int mHalf, mLow, mWrRem, mMaskAcc;
  int eCmd, eRd, eWr, eBank, eRow, eCol, eAp, eMV, eMC, eFlags, eCode;

  task automatic modelReset();
    foreach (mActive[i]) begin mActive[i] = 0; mRow[i] = 0; mAp[i] = 0; end
    mHalf = 2; mLow = 0; mWrRem = 0; mMaskAcc = 0;
    eCmd = 0; eRd = 0; eWr = 0; eBank = 0; eRow = 0; eCol = 0; eAp = 0;
    eMV = 0; eMC = 0; eFlags = 0; eCode = 0;
  endtask

  task automatic modelStep();
    int c, e, b, any, dmn;
    bit idle, blocked, legal;
    b = int'(ba);
    if (csN) c = DESEL;
    else case ({rasN, casN, weN})
      3'b111: c = NOP;
      3'b011: c = ACT;
      3'b101: c = RD;
      3'b100: c = WR;
      3'b010: c = addr[10] ? PREALL : PRE;
      3'b001: c = cke ? REF : 8;
      3'b000: c = MRS;
      default: c = BST;
    endcase
    any = mActive[0] | mActive[1] | mActive[2] | mActive[3];
    idle = (c == DESEL || c == NOP);
    blocked = mLow && !idle;
    e = 0;
    if (blocked) e = 3;
    else if ((c == RD || c == WR) && !mActive[b]) e = 1;
    else if (c == MRS && any != 0) e = 2;
    else if (c == ACT && mActive[b]) e = 4;
    legal = !blocked && e == 0;
    dmn = int'(dm[0]) + int'(dm[1]);
    eMV = (mWrRem == 1);
    if (mWrRem == 1) eMC = mMaskAcc + dmn;
    if (legal && c == WR) begin mWrRem = mHalf; mMaskAcc = 0; end
    else if (mWrRem > 0) begin mWrRem--; mMaskAcc += dmn; end
    eRd = legal && c == RD;
    eWr = legal && c == WR;
    eAp = (eRd || eWr) && addr[10];
    if (eRd || eWr) begin
      eBank = b; eRow = mRow[b];
      eCol = int'(addr[9:0]) + (int'(addr[13:11]) << 10);
    end
    for (int i = 0; i < 4; i++) begin
      if (legal && (c == PREALL || (c == PRE && b == i))) begin
        mActive[i] = 0; mAp[i] = 0;
      end else if (legal && c == ACT && b == i) begin
        mActive[i] = 1; mRow[i] = int'(addr);
      end else if ((eRd || eWr) && b == i && addr[10]) begin
        mAp[i] = mHalf;
      end else if (mAp[i] == 1) begin
        mActive[i] = 0; mAp[i] = 0;
      end else if (mAp[i] > 0) begin
        mAp[i]--;
      end
    end
    if (legal && c == MRS && b == 0 && addr[2:0] >= 1 && addr[2:0] <= 3)
      mHalf = 1 << (int'(addr[2:0]) - 1);
    if (!blocked) begin
      if (!mLow && (c == 8 || (idle && !cke))) mLow = 1;
      else if (mLow && idle && cke) mLow = 0;
    end
    if (e != 0) begin eFlags |= (1 << (e - 1)); eCode = e; end
    eCmd = c;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep();
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 cmdCode", cmdCode, eCmd);
      chk("R2 rdStrobe", rdStrobe, eRd);
      chk("R2 wrStrobe", wrStrobe, eWr);
      chk("R2 burstBank", burstBank, eBank);
      chk("R2 burstRow", burstRow, eRow);
      chk("R2 burstCol", burstCol, eCol);
      chk("R5 autoPre", autoPre, eAp);
      chk("R11 maskValid", maskValid, eMV);
      chk("R11 maskCount", maskCount, eMC);
      chk("R12 errFlags", errFlags, eFlags);
      chk("R12 errCode", errCode, eCode);
    end
  end

  // Drive raw pins at a falling edge, then wait one clock.
  task automatic drive(bit cs, bit [2:0] rcw, int b, int a, bit k, bit [1:0] d);
    csN = cs; {rasN, casN, weN} = rcw; ba = 2'(b); addr = 14'(a); cke = k; dm = d;
    @(negedge clk);
  endtask

  task automatic send(int c, int b = 0, int a = 0, bit k = 1, bit [1:0] d = 0);
    bit [2:0] p;
    case (c)
      ACT: p = 3'b011;  RD: p = 3'b101;  WR: p = 3'b100;
      PRE, PREALL: p = 3'b010;  REF: p = 3'b001;  MRS: p = 3'b000;
      BST: p = 3'b110;  default: p = 3'b111;
    endcase
    drive(c == DESEL, p, b, a, k, d);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset cmdCode", cmdCode, 0);
    chk("R13 reset errFlags", errFlags, 0);
    chk("R13 reset strobes", {rdStrobe, wrStrobe, maskValid, autoPre}, 0);
    rstN = 1'b1;
    send(NOP);
    // R2 / R5: open row, read without auto-precharge
    send(ACT, 1, 'h1234);
    send(RD, 1, 'h0025);
    chk("R2 read strobe", rdStrobe, 1);
    chk("R2 open row", burstRow, 'h1234);
    chk("R2 column", burstCol, 'h25);
    chk("R5 no autoPre", autoPre, 0);
    repeat (5) send(NOP);
    send(RD, 1, 'h0003);
    chk("R5 row still open", rdStrobe, 1);
    // R3: read of idle bank
    send(RD, 2, 'h0001);
    chk("R3 no strobe", rdStrobe, 0);
    chk("R3 error code", errCode, 1);
    // R4: auto-precharge window, burst length 4 (two clocks)
    send(RD, 1, 'h0407);
    chk("R4 autoPre", autoPre, 1);
    send(NOP);
    send(RD, 1, 'h0008);
    chk("R4 last open clock", rdStrobe, 1);
    send(RD, 1, 'h0009);
    chk("R4 closed after burst", rdStrobe, 0);
    // R6: single and all-bank precharge
    send(ACT, 0, 5);
    send(ACT, 3, 7);
    send(PRE, 0, 0);
    send(RD, 3, 0);
    chk("R6 other bank open", rdStrobe, 1);
    chk("R6 other bank row", burstRow, 7);
    send(RD, 0, 0);
    chk("R6 bank closed", rdStrobe, 0);
    send(ACT, 0, 9);
    send(PREALL, 2, 'h0400);
    chk("R6 precharge all code", cmdCode, 6);
    send(RD, 3, 0);
    chk("R6 all closed bank3", rdStrobe, 0);
    send(RD, 0, 0);
    chk("R6 all closed bank0", rdStrobe, 0);
    // R10: activate an open bank
    send(ACT, 2, 'h3FFF);
    send(ACT, 2, 1);
    chk("R10 error code", errCode, 4);
    send(RD, 2, 0);
    chk("R10 row kept", burstRow, 'h3FFF);
    // R7: illegal mode write ignored, burst length stays 4
    send(MRS, 0, 1);
    chk("R7 mode while open", errCode, 2);
    send(PREALL, 0, 'h0400);
    send(ACT, 1, 2);
    send(WR, 1, 3, 1, 2'b11);
    send(NOP, 0, 0, 1, 2'b01);
    chk("R7 length unchanged early", maskValid, 0);
    send(NOP, 0, 0, 1, 2'b11);
    chk("R7 length unchanged", maskValid, 1);
    chk("R11 count short burst", maskCount, 3);
    // R7 legal mode write: burst length 8
    send(PREALL, 0, 'h0400);
    send(MRS, 0, 3);
    chk("R7 mode code", cmdCode, 9);
    chk("R7 no new error", errCode, 2);
    send(ACT, 1, 2);
    send(WR, 1, 'h2805, 1, 2'b11);
    chk("R2 write strobe", wrStrobe, 1);
    chk("R2 write column", burstCol, 'h1405);
    send(NOP, 0, 0, 1, 2'b01);
    send(NOP, 0, 0, 1, 2'b11);
    send(NOP, 0, 0, 1, 2'b00);
    chk("R11 not done", maskValid, 0);
    send(NOP, 0, 0, 1, 2'b10);
    chk("R11 done", maskValid, 1);
    chk("R11 masked beats", maskCount, 4);
    send(NOP);
    chk("R11 pulse ends", maskValid, 0);
    // R8 / R9: refresh kinds and low power
    send(PREALL, 0, 'h0400);
    send(REF, 0, 0, 1);
    chk("R8 auto refresh", cmdCode, 7);
    send(REF, 0, 0, 0);
    chk("R8 self refresh", cmdCode, 8);
    send(ACT, 0, 4, 0);
    chk("R9 blocked in self refresh", errCode, 3);
    send(NOP, 0, 0, 1);
    send(RD, 0, 0);
    chk("R9 blocked act had no effect", errCode, 1);
    send(ACT, 0, 4);
    send(NOP, 0, 0, 0);
    send(NOP, 0, 0, 0);
    send(RD, 0, 0, 0);
    chk("R9 blocked in power-down", errCode, 3);
    chk("R9 no strobe in power-down", rdStrobe, 0);
    send(NOP, 0, 0, 1);
    send(RD, 0, 0);
    chk("R9 row survives power-down", rdStrobe, 1);
    // R1: deselect with activate pins, burst stop
    drive(1'b1, 3'b011, 2, 'h55, 1'b1, 2'b00);
    chk("R1 deselect code", cmdCode, 0);
    send(RD, 2, 0);
    chk("R1 deselect opened nothing", errCode, 1);
    send(BST);
    chk("R1 burst stop code", cmdCode, 10);
    chk("R12 all flags sticky", errFlags, 'hF);
    send(NOP);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule